// File: doc/BRIEF.md
# USB Host Channel Interrupt Status

This block holds the interrupt status of one host channel in a USB host controller. The channel's transaction engine and DMA engine send it single-cycle event pulses. The block latches each pulse into a sticky bit of a 14-bit status word, and software clears bits by writing ones through a plain write port. The block also drives one interrupt request line for the channel. That line is the OR of every status bit that is both enabled by software and allowed by the current DMA mode.

Two DMA modes are supported: a normal mode and a scatter/gather (descriptor list) mode. The mode decides several things. It decides which bits exist, where the transfer-complete and channel-halted events come from, and which bits may raise the interrupt. An internal counter tracks transaction errors that arrive back to back. On the third consecutive error it raises an excessive-error event, and it raises that event only once until a successful transaction or a channel enable resets the count.

Top module: `hc_chan_irq`

## Requirements
- R1: After a synchronous reset, `status` reads 0 and `irq` is 0.
- R2: Each qualified event sets its own bit, and the bit stays set until software clears it. Bit 0 is transfer complete, bit 1 is channel halted, bit 2 is bus error, bit 3 is STALL, bit 4 is NAK, bit 5 is ACK, bit 6 is NYET, bit 7 is transaction error, bit 8 is babble, bit 9 is frame overrun, bit 10 is data toggle error, bit 11 is buffer not available, bit 12 is excessive transaction error and bit 13 is descriptor list rollover. Bits 31:14 always read 0. In both modes, the STALL, NAK, ACK, NYET, transaction error, babble, frame overrun and toggle error pulses set bits 3 to 10.
- R3: When `wr_en` is high, each 1 in `wr_data[13:0]` clears the matching status bit. Each 0 leaves the matching bit unchanged.
- R4: If an event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R5: When `sg_mode` is 0, bits 13:11 read 0 and events cannot set them.
- R6: When `sg_mode` is 1, bits 3 to 10 cannot raise `irq`, whatever `irq_mask` holds.
- R7: The third consecutive `ev_xact_err` pulse sets bit 12 when `sg_mode` is 1. Further errors do not raise the event again until the count is reset. The count is reset by `ev_ack`, `ev_nyet`, `ev_data_rx` or `chan_enable`.
- R8: When `iso_chan` is 1, bits 12 and 11 are never set.
- R9: `ev_bus_err` sets bit 2 only when `dma_en` is 1.
- R10: When `sg_mode` is 1, bit 1 is set by an end-of-list descriptor, a qualified bus error, the excessive-error event, babble or STALL, and `ev_halt` is ignored. When `sg_mode` is 0, bit 1 is set only by `ev_halt`.
- R11: Bit 0 is set by `ev_desc_ioc` when `sg_mode` is 1 and by `ev_xfer_done` when `sg_mode` is 0. The other source has no effect in each mode.
- R12: `irq` is registered. It equals the OR over all bits of (status AND `irq_mask` AND mode allowance), taken one cycle after the status changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sg_mode | input | 1 | 1 = scatter/gather DMA mode |
| dma_en | input | 1 | Internal DMA enabled |
| iso_chan | input | 1 | Channel carries isochronous traffic |
| chan_enable | input | 1 | Channel enable pulse; resets the error count |
| ev_xfer_done | input | 1 | Normal-mode transfer finished without error |
| ev_desc_ioc | input | 1 | Descriptor with interrupt-on-completion finished |
| ev_desc_eol | input | 1 | End-of-list descriptor finished |
| ev_halt | input | 1 | Normal-mode channel halt |
| ev_bus_err | input | 1 | System bus error during DMA |
| ev_stall | input | 1 | STALL handshake |
| ev_nak | input | 1 | NAK handshake |
| ev_ack | input | 1 | ACK handshake |
| ev_nyet | input | 1 | NYET handshake |
| ev_xact_err | input | 1 | Transaction error (CRC, timeout, bit stuff, false EOP) |
| ev_babble | input | 1 | Babble detected |
| ev_frm_ovr | input | 1 | Frame overrun |
| ev_tgl_err | input | 1 | Data toggle mismatch |
| ev_bna | input | 1 | Descriptor not ready |
| ev_rollover | input | 1 | Descriptor list rolled over |
| ev_data_rx | input | 1 | Data packet received successfully |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 32 | Write-one-to-clear data |
| irq_mask | input | 14 | Per-bit interrupt enable |
| status | output | 32 | Status word |
| irq | output | 1 | Channel interrupt request |

## Verification
A table drives every event pulse on its own in each DMA mode, with `dma_en` and `iso_chan` varied. This separates the mode-steered sources of bits 0 and 1, the reserved bits 13:11 and the bus-error gate. Directed sequences of transaction errors then vary the spacing of errors against ACK, NYET, received data and channel enable, and one sequence runs on an isochronous channel. These show whether the count resets, whether it saturates, and whether the event fires exactly once. Further sequences pair a clear with a set on the same bit, and watch `irq` over two cycles while the mask and the mode are changed.

// File: rtl/hcirq_pkg.sv
package hcirq_pkg;

    localparam int STAT_W    = 14;
    localparam int BUS_W     = 32;
    localparam int ERR_LIMIT = 3;

    localparam int B_XFER   = 0;
    localparam int B_HALT   = 1;
    localparam int B_BUSERR = 2;
    localparam int B_STALL  = 3;
    localparam int B_NAK    = 4;
    localparam int B_ACK    = 5;
    localparam int B_NYET   = 6;
    localparam int B_XACT   = 7;
    localparam int B_BABBLE = 8;
    localparam int B_FRMOVR = 9;
    localparam int B_TGLERR = 10;
    localparam int B_BNA    = 11;
    localparam int B_EXCESS = 12;
    localparam int B_ROLL   = 13;

    typedef logic [STAT_W-1:0] stat_vec_t;

    typedef struct packed {
        logic xfer_done;
        logic desc_ioc;
        logic desc_eol;
        logic halt_req;
        logic bus_err;
        logic stall;
        logic nak;
        logic ack;
        logic nyet;
        logic xact_err;
        logic babble;
        logic frm_ovr;
        logic tgl_err;
        logic bna;
        logic rollover;
        logic data_rx;
    } chan_evt_t;

    // Bits that only exist in descriptor-list mode.
    function automatic stat_vec_t sg_only_bits();
        stat_vec_t v = '0;
        for (int i = B_BNA; i <= B_ROLL; i++) v[i] = 1'b1;
        return v;
    endfunction

    // Bits whose interrupt is suppressed in descriptor-list mode.
    function automatic stat_vec_t sg_quiet_bits();
        stat_vec_t v = '0;
        for (int i = B_STALL; i <= B_TGLERR; i++) v[i] = 1'b1;
        return v;
    endfunction

    function automatic stat_vec_t valid_bits(input logic sg);
        return sg ? '1 : ~sg_only_bits();
    endfunction

    function automatic stat_vec_t irq_allow(input logic sg);
        return sg ? ~sg_quiet_bits() : '1;
    endfunction

endpackage

// File: rtl/hcirq_err_track.sv
module hcirq_err_track #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic xact_err,
    input  logic success,
    input  logic restart,
    output logic excess
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP  = CW'(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          clr;

    assign clr    = success | restart;
    assign excess = xact_err & ~clr & (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (xact_err && cnt_q != TOP)
            cnt_q <= cnt_q + 1'b1;
    end

    assert_once_R7: assert property (@(posedge clk) disable iff (rst)
        excess |=> (cnt_q == TOP));

    assert_saturate_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == TOP) && !clr |=> (cnt_q == TOP) && !excess);

endmodule

// File: rtl/hcirq_qualify.sv
module hcirq_qualify
    import hcirq_pkg::*;
(
    input  chan_evt_t evt,
    input  logic      sg_mode,
    input  logic      dma_en,
    input  logic      iso_chan,
    input  logic      excess,
    output stat_vec_t set_vec
);
    logic bus_ok;
    logic excess_ok;

    assign bus_ok    = evt.bus_err & dma_en;
    assign excess_ok = sg_mode & excess & ~iso_chan;

    always_comb begin
        set_vec           = '0;
        set_vec[B_XFER]   = sg_mode ? evt.desc_ioc : evt.xfer_done;
        set_vec[B_HALT]   = sg_mode ? (evt.desc_eol | bus_ok | excess_ok |
                                       evt.babble | evt.stall)
                                    : evt.halt_req;
        set_vec[B_BUSERR] = bus_ok;
        set_vec[B_STALL]  = evt.stall;
        set_vec[B_NAK]    = evt.nak;
        set_vec[B_ACK]    = evt.ack;
        set_vec[B_NYET]   = evt.nyet;
        set_vec[B_XACT]   = evt.xact_err;
        set_vec[B_BABBLE] = evt.babble;
        set_vec[B_FRMOVR] = evt.frm_ovr;
        set_vec[B_TGLERR] = evt.tgl_err;
        set_vec[B_BNA]    = sg_mode & evt.bna & ~iso_chan;
        set_vec[B_EXCESS] = excess_ok;
        set_vec[B_ROLL]   = sg_mode & evt.rollover;
    end

endmodule

// File: rtl/hcirq_status.sv
module hcirq_status #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic [W-1:0] keep,
    output logic [W-1:0] stat_q
);
    logic [W-1:0] stat_d;

    // A set in the same cycle as a clear wins.
    assign stat_d = ((stat_q & ~clr_vec) | set_vec) & keep;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
            clr_vec[i] && !set_vec[i] |=> !stat_q[i]);
        assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
            stat_q[i] && !clr_vec[i] && keep[i] |=> stat_q[i]);
    end

endmodule

// File: rtl/hcirq_irq_gen.sv
module hcirq_irq_gen #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] stat,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] allow,
    output logic         irq
);
    logic [W-1:0] live;

    assign live = stat & mask & allow;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |live;
    end

    assert_irq_cause_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|(stat & mask & allow)));

endmodule

// File: rtl/hc_chan_irq.sv
module hc_chan_irq
    import hcirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sg_mode,
    input  logic              dma_en,
    input  logic              iso_chan,
    input  logic              chan_enable,
    input  logic              ev_xfer_done,
    input  logic              ev_desc_ioc,
    input  logic              ev_desc_eol,
    input  logic              ev_halt,
    input  logic              ev_bus_err,
    input  logic              ev_stall,
    input  logic              ev_nak,
    input  logic              ev_ack,
    input  logic              ev_nyet,
    input  logic              ev_xact_err,
    input  logic              ev_babble,
    input  logic              ev_frm_ovr,
    input  logic              ev_tgl_err,
    input  logic              ev_bna,
    input  logic              ev_rollover,
    input  logic              ev_data_rx,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [STAT_W-1:0] irq_mask,
    output logic [BUS_W-1:0]  status,
    output logic              irq
);
    chan_evt_t evt;
    stat_vec_t set_vec, clr_vec, keep, stat_q;
    logic      excess;
    logic      unused_hi;

    assign evt = '{xfer_done: ev_xfer_done, desc_ioc: ev_desc_ioc,
                   desc_eol: ev_desc_eol, halt_req: ev_halt,
                   bus_err: ev_bus_err, stall: ev_stall, nak: ev_nak,
                   ack: ev_ack, nyet: ev_nyet, xact_err: ev_xact_err,
                   babble: ev_babble, frm_ovr: ev_frm_ovr,
                   tgl_err: ev_tgl_err, bna: ev_bna,
                   rollover: ev_rollover, data_rx: ev_data_rx};

    assign unused_hi = ^wr_data[BUS_W-1:STAT_W];
    assign clr_vec   = wr_en ? wr_data[STAT_W-1:0] : '0;
    assign keep      = valid_bits(sg_mode);

    hcirq_err_track #(.LIMIT(ERR_LIMIT)) u_err (
        .clk      (clk),
        .rst      (rst),
        .xact_err (evt.xact_err),
        .success  (evt.ack | evt.nyet | evt.data_rx),
        .restart  (chan_enable),
        .excess   (excess)
    );

    hcirq_qualify u_qual (
        .evt      (evt),
        .sg_mode  (sg_mode),
        .dma_en   (dma_en),
        .iso_chan (iso_chan),
        .excess   (excess),
        .set_vec  (set_vec)
    );

    hcirq_status #(.W(STAT_W)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .keep    (keep),
        .stat_q  (stat_q)
    );

    hcirq_irq_gen #(.W(STAT_W)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .stat  (status[STAT_W-1:0]),
        .mask  (irq_mask),
        .allow (irq_allow(sg_mode)),
        .irq   (irq)
    );

    assign status = {{(BUS_W-STAT_W){1'b0}}, stat_q & keep};

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        ev_stall && wr_en && wr_data[B_STALL] |=> status[B_STALL]);

    assert_reserved_R5: assert property (@(posedge clk) disable iff (rst)
        !sg_mode && $past(!sg_mode) |-> (status[BUS_W-1:B_BNA] == '0));

endmodule

// File: tb/tb_hc_chan_irq.sv
module tb_hc_chan_irq;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 20;

    // Bench event word bit order.
    localparam int E_XFER = 0, E_IOC = 1, E_EOL = 2, E_HALT = 3, E_BUS = 4,
                   E_STALL = 5, E_NAK = 6, E_ACK = 7, E_NYET = 8, E_XACT = 9,
                   E_BAB = 10, E_FRM = 11, E_TGL = 12, E_BNA = 13, E_ROLL = 14,
                   E_RX = 15;

    // {sg, dma, iso, event word, expected status}
    localparam logic [32:0] VECS [NVEC] = '{
        {1'b0,1'b1,1'b0,16'h0001,14'h0001},  // R11 normal done
        {1'b0,1'b1,1'b0,16'h0002,14'h0000},  // R11 ioc ignored
        {1'b1,1'b1,1'b0,16'h0002,14'h0001},  // R11 ioc in sg
        {1'b1,1'b1,1'b0,16'h0001,14'h0000},  // R11 done ignored in sg
        {1'b0,1'b1,1'b0,16'h0008,14'h0002},  // R10 halt normal
        {1'b1,1'b1,1'b0,16'h0008,14'h0000},  // R10 halt ignored sg
        {1'b1,1'b1,1'b0,16'h0004,14'h0002},  // R10 eol
        {1'b0,1'b1,1'b0,16'h0004,14'h0000},  // R10 eol ignored normal
        {1'b0,1'b1,1'b0,16'h0010,14'h0004},  // R9 bus err
        {1'b0,1'b0,1'b0,16'h0010,14'h0000},  // R9 no dma
        {1'b1,1'b1,1'b0,16'h0010,14'h0006},  // R10 bus err halts sg
        {1'b1,1'b1,1'b0,16'h0020,14'h000A},  // R10 stall halts sg
        {1'b0,1'b1,1'b0,16'h0020,14'h0008},  // R2 stall normal
        {1'b1,1'b1,1'b0,16'h0400,14'h0102},  // R10 babble halts sg
        {1'b0,1'b1,1'b0,16'h1BC0,14'h06F0},  // R2 handshakes+errors
        {1'b1,1'b1,1'b0,16'h2000,14'h0800},  // R2 bna sg
        {1'b0,1'b1,1'b0,16'h2000,14'h0000},  // R5 bna normal
        {1'b1,1'b1,1'b0,16'h4000,14'h2000},  // R2 rollover sg
        {1'b0,1'b1,1'b0,16'h4000,14'h0000},  // R5 rollover normal
        {1'b1,1'b1,1'b1,16'h2000,14'h0000}   // R8 bna iso
    };

    logic clk = 0, rst = 1;
    logic sg_mode = 0, dma_en = 1, iso_chan = 0, chan_enable = 0;
    logic [15:0] ev = '0;
    logic wr_en = 0;
    logic [31:0] wr_data = '0;
    logic [13:0] irq_mask = '0;
    logic [31:0] status;
    logic irq;
    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hc_chan_irq dut (
        .clk(clk), .rst(rst), .sg_mode(sg_mode), .dma_en(dma_en),
        .iso_chan(iso_chan), .chan_enable(chan_enable),
        .ev_xfer_done(ev[E_XFER]), .ev_desc_ioc(ev[E_IOC]),
        .ev_desc_eol(ev[E_EOL]), .ev_halt(ev[E_HALT]), .ev_bus_err(ev[E_BUS]),
        .ev_stall(ev[E_STALL]), .ev_nak(ev[E_NAK]), .ev_ack(ev[E_ACK]),
        .ev_nyet(ev[E_NYET]), .ev_xact_err(ev[E_XACT]), .ev_babble(ev[E_BAB]),
        .ev_frm_ovr(ev[E_FRM]), .ev_tgl_err(ev[E_TGL]), .ev_bna(ev[E_BNA]),
        .ev_rollover(ev[E_ROLL]), .ev_data_rx(ev[E_RX]),
        .wr_en(wr_en), .wr_data(wr_data), .irq_mask(irq_mask),
        .status(status), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Pulse events for one cycle; status is visible on return.
    task automatic pulse(input logic [15:0] e);
        @(negedge clk); ev = e;
        @(negedge clk); ev = '0;
    endtask

    task automatic wclr(input logic [31:0] d, input logic restart);
        @(negedge clk); wr_en = 1; wr_data = d; chan_enable = restart;
        @(negedge clk); wr_en = 0; wr_data = '0; chan_enable = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 status after reset", status, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            sg_mode = VECS[i][32]; dma_en = VECS[i][31]; iso_chan = VECS[i][30];
            wclr(32'hFFFF_FFFF, 1'b1);
            pulse(VECS[i][29:14]);
            check($sformatf("vector %0d (R2/R5/R8-R11)", i), status,
                  {18'b0, VECS[i][13:0]});
        end

        // R2 upper bits stay zero
        sg_mode = 1; dma_en = 1; iso_chan = 0;
        wclr(32'hFFFF_FFFF, 1'b1);
        pulse(16'hFFFF);
        check("R2 upper bits zero", status >> 14, 32'h0);

        // R3 write-one-to-clear
        sg_mode = 0;
        wclr(32'hFFFF_FFFF, 1'b1);
        pulse((16'h1 << E_STALL) | (16'h1 << E_NAK));
        wclr(32'h0000_0010, 1'b0);
        check("R3 clear nak only", status, 32'h0008);
        wclr(32'h0000_0000, 1'b0);
        check("R3 zero write keeps", status, 32'h0008);

        // R4 set wins
        wclr(32'hFFFF_FFFF, 1'b0);
        @(negedge clk); ev = 16'h1 << E_STALL; wr_en = 1; wr_data = 32'h8;
        @(negedge clk); ev = '0; wr_en = 0; wr_data = '0;
        check("R4 set beats clear", status, 32'h0008);

        // R7 consecutive errors
        sg_mode = 1; iso_chan = 0;
        wclr(32'hFFFF_FFFF, 1'b1);
        pulse(16'h1 << E_XACT);
        pulse(16'h1 << E_XACT);
        check("R7 two errors no excess", status, 32'h0080);
        pulse(16'h1 << E_XACT);
        check("R7 third error excess+halt", status, 32'h1082);
        wclr(32'hFFFF_FFFF, 1'b0);
        pulse(16'h1 << E_XACT);
        check("R7 fourth error only once", status, 32'h0080);
        pulse(16'h1 << E_ACK);
        pulse(16'h1 << E_XACT);
        pulse(16'h1 << E_XACT);
        wclr(32'hFFFF_FFFF, 1'b0);
        pulse(16'h1 << E_XACT);
        check("R7 ack restarts count", status, 32'h1082);
        wclr(32'hFFFF_FFFF, 1'b1);
        pulse(16'h1 << E_XACT); pulse(16'h1 << E_XACT);
        pulse(16'h1 << E_NYET);
        wclr(32'hFFFF_FFFF, 1'b0);
        pulse(16'h1 << E_XACT);
        check("R7 nyet resets count", status, 32'h0080);
        wclr(32'hFFFF_FFFF, 1'b1);
        pulse(16'h1 << E_XACT); pulse(16'h1 << E_XACT);
        pulse(16'h1 << E_RX);
        pulse(16'h1 << E_XACT);
        check("R7 data rx resets count", status, 32'h0080);
        wclr(32'hFFFF_FFFF, 1'b1);
        pulse(16'h1 << E_XACT); pulse(16'h1 << E_XACT);
        wclr(32'h0, 1'b1);
        pulse(16'h1 << E_XACT);
        check("R7 chan enable resets count", status, 32'h0080);

        // R8 isochronous
        iso_chan = 1;
        wclr(32'hFFFF_FFFF, 1'b1);
        pulse(16'h1 << E_XACT); pulse(16'h1 << E_XACT); pulse(16'h1 << E_XACT);
        check("R8 iso no excess", status, 32'h0080);
        iso_chan = 0;

        // R5 excess reserved in normal mode
        sg_mode = 0;
        wclr(32'hFFFF_FFFF, 1'b1);
        pulse(16'h1 << E_XACT); pulse(16'h1 << E_XACT); pulse(16'h1 << E_XACT);
        check("R5 no excess in normal mode", status, 32'h0080);

        // R12 registered irq
        irq_mask = '1;
        wclr(32'hFFFF_FFFF, 1'b1);
        @(negedge clk);
        check("R12 irq low when clear", {31'b0, irq}, 32'h0);
        pulse(16'h1 << E_NAK);
        check("R12 irq not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R12 irq one cycle later", {31'b0, irq}, 32'h1);
        wclr(32'hFFFF_FFFF, 1'b0);
        @(negedge clk);
        check("R12 irq drops after clear", {31'b0, irq}, 32'h0);
        irq_mask = 14'h3FEF;
        pulse(16'h1 << E_NAK);
        @(negedge clk);
        check("R12 masked bit no irq", {31'b0, irq}, 32'h0);

        // R6 sg suppresses bits 3..10
        irq_mask = '1; sg_mode = 1;
        wclr(32'hFFFF_FFFF, 1'b1);
        pulse((16'h1 << E_NAK) | (16'h1 << E_ACK) | (16'h1 << E_TGL));
        @(negedge clk);
        check("R6 quiet bits in sg", {31'b0, irq}, 32'h0);
        pulse(16'h1 << E_ROLL);
        @(negedge clk);
        check("R6 rollover raises irq", {31'b0, irq}, 32'h1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule